// File: doc/BRIEF.md
# TCP Response Timeout and Retry Controller

This block supervises one TCP session. It watches for the reply that each phase of the session is waiting for, and it decides how to recover when that reply does not come in time. A single timer counts clock cycles up to a programmed limit. The limit is given in clock periods, and values above 0x6000 are the intended operating range. The timer reloads whenever the expected reply is reported or the phase changes.

When the timer expires, the block raises one request pulse that says which packet the transmit side must send next. The request depends on the phase:

- Some phases retry with no limit.
- Open phases and the passive close phase resend up to sixteen times and then escalate to a teardown packet.
- Active close escalates to a reset on the first expiry.

Each expiry also raises a one-cycle interrupt and sets a cause bit in a status word. The status bits stay set until the block is reset.

The session sequencer drives the phase code and the reply pulses. The packet builder consumes the request pulses. Payload handling and header checks stay outside this block.

Top module: `tcpRetryTimer`

## Requirements
- R1: While rstN is low and in the first cycle after it is released, every request output, tmoIrq and tmoStatus are zero.
- R2: With limit T (T ≥ 2) and no reply, the first expiry pulse appears on the T-th clock edge after the edge that takes a new phase. Further expiry pulses follow every T cycles.
- R3: A replyOk pulse reloads the timer, so the next expiry comes T cycles after the edge that took replyOk.
- R4: In phase 1 (address resolution), every expiry requests reqArp and sets status bit 0. There is no retry limit.
- R5: In phase 2 (active open), the first 16 expiries request reqSyn. Every later expiry requests reqFin. Status bit 1 is set.
- R6: In phase 3 (passive open), the first 16 expiries request reqSynAck. Every later expiry requests reqFin. Status bit 2 is set.
- R7: In phase 4 (active close), every expiry, including the first, requests reqRst and sets status bit 3.
- R8: In phase 5 (passive close), the first 16 expiries request reqFinAck. Every later expiry requests reqRst. Status bit 4 is set.
- R9: In phase 6 (data send), an expiry requests reqData. It sets status bit 7 when winRetxEn, sendPending and winSmall are all high. Otherwise it sets status bit 5.
- R10: In phase 7 (data receive), the timer runs only while rxFault is high. An expiry requests reqDupAck and sets status bit 6.
- R11: tmoIrq is high for exactly one cycle per expiry. Exactly one request output is high in that same cycle, and none is high otherwise.
- R12: Status bits are sticky. They accumulate across phases and clear only on reset.
- R13: In phase 0 (idle), the timer does not run. Every phase change clears the retry count, so a re-entered phase gets 16 fresh retries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; timer unit is one period |
| rstN | input | 1 | Active-low synchronous reset |
| timeoutVal | input | 32 | Timeout limit in clock cycles |
| phase | input | 3 | Current session phase code (0 idle … 7 receive) |
| replyOk | input | 1 | Pulse: the awaited reply arrived |
| rxFault | input | 1 | Receive side has a lost packet, full buffer or bad sequence |
| winRetxEn | input | 1 | Enables window-stall retransmission |
| sendPending | input | 1 | A send command still has data outstanding |
| winSmall | input | 1 | Peer window is smaller than the packet size |
| reqArp | output | 1 | Pulse: resend address resolution request |
| reqSyn | output | 1 | Pulse: resend SYN |
| reqSynAck | output | 1 | Pulse: resend SYN/ACK |
| reqFin | output | 1 | Pulse: send FIN |
| reqFinAck | output | 1 | Pulse: resend FIN/ACK |
| reqRst | output | 1 | Pulse: send RST |
| reqData | output | 1 | Pulse: retransmit previous data packet |
| reqDupAck | output | 1 | Pulse: send duplicate ACK |
| tmoIrq | output | 1 | One-cycle timeout interrupt |
| tmoStatus | output | 8 | Sticky timeout cause bits |

## Verification
Some properties are checked by assertions on every cycle:

- The interrupt and the request outputs always agree, with exactly one request per interrupt.
- The retry count never passes its cap.
- The timer never passes the limit.
- Status bits never fall.
- Active close only ever asks for a reset.

Other behaviour is shown only by the bench scenarios:

- The exact expiry cycle after a phase change or after a reply.
- The switch from plain retries to escalation on the seventeenth expiry.
- The fresh retry budget after a phase is re-entered.
- The gating of the receive timer by the fault input.

// File: rtl/tmoPkg.sv
`timescale 1ns/1ps
package tmoPkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ARP    = 3'd1,
    PH_AOPEN  = 3'd2,
    PH_POPEN  = 3'd3,
    PH_ACLOSE = 3'd4,
    PH_PCLOSE = 3'd5,
    PH_SEND   = 3'd6,
    PH_RECV   = 3'd7
  } phase_e;

  // strobes from the decision logic to the timer path
  typedef struct packed {
    logic clrTimer;
    logic run;
    logic bumpRetry;
  } tmoStrobe_t;

  typedef struct packed {
    logic arp;
    logic syn;
    logic synAck;
    logic fin;
    logic finAck;
    logic rst;
    logic data;
    logic dupAck;
  } reqVec_t;

  localparam int NUM_CAUSE = 8;

endpackage

// File: rtl/tmoTimerPath.sv
`timescale 1ns/1ps
module tmoTimerPath
  import tmoPkg::*;
#(
  parameter int TMR_W       = 32,
  parameter int RETRY_LIMIT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMR_W-1:0] timeoutVal,
  input  logic [2:0]       phaseIn,
  input  tmoStrobe_t       strb,
  output logic             phaseChg,
  output logic             expire,
  output logic             retryExhausted
);

  localparam int RTY_W = $clog2(RETRY_LIMIT + 1);
  localparam logic [RTY_W-1:0] RTY_CAP = RTY_W'(RETRY_LIMIT);

  logic [2:0]       phaseQ;
  logic [TMR_W-1:0] cnt;
  logic [RTY_W-1:0] rty;
  logic [TMR_W:0]   cntNext1;

  assign phaseChg = (phaseIn != phaseQ);
  assign cntNext1 = {1'b0, cnt} + {{TMR_W{1'b0}}, 1'b1};
  assign expire   = strb.run && !strb.clrTimer && (cntNext1 >= {1'b0, timeoutVal});
  assign retryExhausted = (rty >= RTY_CAP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= 3'(PH_IDLE);
    end else begin
      phaseQ <= phaseIn;
    end
  end

  // cycle timer: reload on reply, phase change, expiry or when halted
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.clrTimer || !strb.run || expire) begin
      cnt <= '0;
    end else begin
      cnt <= cntNext1[TMR_W-1:0];
    end
  end

  // retry counter: cleared on phase change, saturates at the cap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rty <= '0;
    end else if (phaseChg) begin
      rty <= '0;
    end else if (strb.bumpRetry && (rty < RTY_CAP)) begin
      rty <= rty + RTY_W'(1);
    end
  end

  // R13
  retry_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    rty <= RTY_CAP);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && (timeoutVal != '0) && $stable(timeoutVal)) |-> (cnt < timeoutVal));

endmodule

// File: rtl/tmoDecide.sv
`timescale 1ns/1ps
module tmoDecide
  import tmoPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           phaseIn,
  input  logic                 replyOk,
  input  logic                 rxFault,
  input  logic                 winRetxEn,
  input  logic                 sendPending,
  input  logic                 winSmall,
  input  logic                 phaseChg,
  input  logic                 expire,
  input  logic                 retryExhausted,
  output tmoStrobe_t           strb,
  output reqVec_t              reqOut,
  output logic                 irqOut,
  output logic [NUM_CAUSE-1:0] statusOut
);

  phase_e               phaseE;
  reqVec_t              reqNext;
  reqVec_t              reqQ;
  logic [NUM_CAUSE-1:0] causeNext;
  logic [NUM_CAUSE-1:0] statusQ;
  logic                 bumpNext;
  logic                 bumpQ;
  logic                 irqQ;
  logic                 winStall;

  assign phaseE   = phase_e'(phaseIn);
  assign winStall = winRetxEn && sendPending && winSmall;

  assign strb.clrTimer  = phaseChg || replyOk;
  assign strb.run       = (phaseE != PH_IDLE) && ((phaseE != PH_RECV) || rxFault);
  assign strb.bumpRetry = bumpQ;

  always_comb begin
    reqNext   = '0;
    causeNext = '0;
    bumpNext  = 1'b0;
    if (expire) begin
      case (phaseE)
        PH_ARP: begin
          reqNext.arp  = 1'b1;
          causeNext[0] = 1'b1;
        end
        PH_AOPEN: begin
          causeNext[1] = 1'b1;
          if (retryExhausted) begin
            reqNext.fin = 1'b1;
          end else begin
            reqNext.syn = 1'b1;
            bumpNext    = 1'b1;
          end
        end
        PH_POPEN: begin
          causeNext[2] = 1'b1;
          if (retryExhausted) begin
            reqNext.fin = 1'b1;
          end else begin
            reqNext.synAck = 1'b1;
            bumpNext       = 1'b1;
          end
        end
        PH_ACLOSE: begin
          causeNext[3] = 1'b1;
          reqNext.rst  = 1'b1;
        end
        PH_PCLOSE: begin
          causeNext[4] = 1'b1;
          if (retryExhausted) begin
            reqNext.rst = 1'b1;
          end else begin
            reqNext.finAck = 1'b1;
            bumpNext       = 1'b1;
          end
        end
        PH_SEND: begin
          reqNext.data = 1'b1;
          if (winStall) causeNext[7] = 1'b1;
          else          causeNext[5] = 1'b1;
        end
        PH_RECV: begin
          reqNext.dupAck = 1'b1;
          causeNext[6]   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ    <= '0;
      irqQ    <= 1'b0;
      bumpQ   <= 1'b0;
      statusQ <= '0;
    end else begin
      reqQ    <= reqNext;
      irqQ    <= expire;
      bumpQ   <= bumpNext;
      statusQ <= statusQ | causeNext;
    end
  end

  assign reqOut    = reqQ;
  assign irqOut    = irqQ;
  assign statusOut = statusQ;

  // R11
  irq_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> ($countones(reqQ) == 1));

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqQ |-> (reqQ == '0));

  // R12
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R12
  irq_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> (statusQ != '0));

  // R7
  aclose_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && ($past(phaseE) == PH_ACLOSE)) |-> reqQ.rst);

  // R10
  recv_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqQ.dupAck |-> ($past(phaseE) == PH_RECV));

endmodule

// File: rtl/tcpRetryTimer.sv
`timescale 1ns/1ps
module tcpRetryTimer
  import tmoPkg::*;
#(
  parameter int TMR_W       = 32,
  parameter int RETRY_LIMIT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMR_W-1:0] timeoutVal,
  input  logic [2:0]       phase,
  input  logic             replyOk,
  input  logic             rxFault,
  input  logic             winRetxEn,
  input  logic             sendPending,
  input  logic             winSmall,
  output logic             reqArp,
  output logic             reqSyn,
  output logic             reqSynAck,
  output logic             reqFin,
  output logic             reqFinAck,
  output logic             reqRst,
  output logic             reqData,
  output logic             reqDupAck,
  output logic             tmoIrq,
  output logic [7:0]       tmoStatus
);

  tmoStrobe_t           strb;
  reqVec_t              reqV;
  logic                 phaseChg;
  logic                 expire;
  logic                 retryExhausted;
  logic [NUM_CAUSE-1:0] statusW;

  tmoTimerPath #(
    .TMR_W      (TMR_W),
    .RETRY_LIMIT(RETRY_LIMIT)
  ) u_path (
    .clk           (clk),
    .rstN          (rstN),
    .timeoutVal    (timeoutVal),
    .phaseIn       (phase),
    .strb          (strb),
    .phaseChg      (phaseChg),
    .expire        (expire),
    .retryExhausted(retryExhausted)
  );

  tmoDecide u_decide (
    .clk           (clk),
    .rstN          (rstN),
    .phaseIn       (phase),
    .replyOk       (replyOk),
    .rxFault       (rxFault),
    .winRetxEn     (winRetxEn),
    .sendPending   (sendPending),
    .winSmall      (winSmall),
    .phaseChg      (phaseChg),
    .expire        (expire),
    .retryExhausted(retryExhausted),
    .strb          (strb),
    .reqOut        (reqV),
    .irqOut        (tmoIrq),
    .statusOut     (statusW)
  );

  assign reqArp    = reqV.arp;
  assign reqSyn    = reqV.syn;
  assign reqSynAck = reqV.synAck;
  assign reqFin    = reqV.fin;
  assign reqFinAck = reqV.finAck;
  assign reqRst    = reqV.rst;
  assign reqData   = reqV.data;
  assign reqDupAck = reqV.dupAck;
  assign tmoStatus = statusW;

endmodule

// File: tb/tcpRetryTimer_bench.sv
`timescale 1ns/1ps
module tcpRetryTimer_bench;

  localparam int T = 6;
  localparam int ESC_WIN = 17 * T + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] timeoutVal = 32'(T);
  logic [2:0]  phase = 3'd0;
  logic        replyOk = 1'b0;
  logic        rxFault = 1'b0;
  logic        winRetxEn = 1'b0;
  logic        sendPending = 1'b0;
  logic        winSmall = 1'b0;
  logic        reqArp, reqSyn, reqSynAck, reqFin, reqFinAck, reqRst, reqData, reqDupAck;
  logic        tmoIrq;
  logic [7:0]  tmoStatus;
  logic [7:0]  reqBits;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  assign reqBits = {reqArp, reqSyn, reqSynAck, reqFin, reqFinAck, reqRst, reqData, reqDupAck};

  tcpRetryTimer u_tcpRetryTimer (
    .clk(clk), .rstN(rstN), .timeoutVal(timeoutVal), .phase(phase),
    .replyOk(replyOk), .rxFault(rxFault), .winRetxEn(winRetxEn),
    .sendPending(sendPending), .winSmall(winSmall),
    .reqArp(reqArp), .reqSyn(reqSyn), .reqSynAck(reqSynAck), .reqFin(reqFin),
    .reqFinAck(reqFinAck), .reqRst(reqRst), .reqData(reqData), .reqDupAck(reqDupAck),
    .tmoIrq(tmoIrq), .tmoStatus(tmoStatus)
  );

  // {phase, winRetxEn, sendPending, winSmall, rxFault, expected request bits, expected status}
  localparam logic [22:0] VECS [0:8] = '{
    {3'd1, 4'b0000, 8'h80, 8'h01},  // R4
    {3'd2, 4'b0000, 8'h40, 8'h02},  // R5
    {3'd3, 4'b0000, 8'h20, 8'h04},  // R6
    {3'd4, 4'b0000, 8'h04, 8'h08},  // R7
    {3'd5, 4'b0000, 8'h08, 8'h10},  // R8
    {3'd6, 4'b0000, 8'h02, 8'h20},  // R9
    {3'd6, 4'b1110, 8'h02, 8'h80},  // R9
    {3'd6, 4'b1100, 8'h02, 8'h20},  // R9
    {3'd7, 4'b0001, 8'h01, 8'h40}   // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0; phase = 3'd0; replyOk = 1'b0; rxFault = 1'b0;
    winRetxEn = 1'b0; sendPending = 1'b0; winSmall = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // count normal and escalated pulses over 17 timeout periods
  task automatic escalate(input logic [2:0] ph, input logic [7:0] normMask,
                          input logic [7:0] escMask, input string tag);
    int nNorm = 0;
    int nEsc = 0;
    int escAt = 0;
    phase = ph;
    for (int i = 1; i <= ESC_WIN; i++) begin
      @(negedge clk);
      if (reqBits == normMask) nNorm++;
      if (reqBits == escMask) begin nEsc++; escAt = i; end
    end
    chk({tag, " normal retries"}, 32'(nNorm), 32'd16);
    chk({tag, " escalations"}, 32'(nEsc), 32'd1);
    chk({tag, " escalation cycle"}, 32'(escAt), 32'(ESC_WIN));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    int cntP;

    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 reqs in reset", 32'(reqBits), 32'h0);
    chk("R1 irq in reset", 32'(tmoIrq), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", 32'(tmoStatus), 32'h0);

    // table walk: R2 timing, R11 single-cycle pulse, per-phase action
    for (int v = 0; v < 9; v++) begin
      resetDut();
      {winRetxEn, sendPending, winSmall, rxFault} = VECS[v][19:16];
      phase = VECS[v][22:20];
      repeat (T) @(negedge clk);
      chk($sformatf("R2 row %0d quiet before expiry", v), 32'({tmoIrq, reqBits}), 32'h0);
      @(negedge clk);
      chk($sformatf("R2 row %0d request", v), 32'(reqBits), 32'(VECS[v][15:8]));
      chk($sformatf("R11 row %0d irq", v), 32'(tmoIrq), 32'h1);
      chk($sformatf("R12 row %0d status", v), 32'(tmoStatus), 32'(VECS[v][7:0]));
      @(negedge clk);
      chk($sformatf("R11 row %0d one cycle", v), 32'({tmoIrq, reqBits}), 32'h0);
      repeat (T - 1) @(negedge clk);
      chk($sformatf("R2 row %0d repeat", v), 32'(reqBits), 32'(VECS[v][15:8]));
    end

    // R4: address resolution retries without limit
    resetDut();
    cntP = 0;
    phase = 3'd1;
    for (int i = 1; i <= 20 * T + 1; i++) begin
      @(negedge clk);
      if (reqArp) cntP++;
    end
    chk("R4 unlimited arp retries", 32'(cntP), 32'd20);

    // R5, R6, R8: 16 retries then escalation
    resetDut();
    escalate(3'd2, 8'h40, 8'h10, "R5 active open");
    resetDut();
    escalate(3'd3, 8'h20, 8'h10, "R6 passive open");
    resetDut();
    escalate(3'd5, 8'h08, 8'h04, "R8 passive close");

    // R13: retry count cleared by phase change
    resetDut();
    phase = 3'd2;
    repeat (10 * T + 1) @(negedge clk);
    phase = 3'd0;
    @(negedge clk);
    escalate(3'd2, 8'h40, 8'h10, "R13 re-entered open");

    // R3: reply reloads timer
    resetDut();
    phase = 3'd1;
    repeat (T - 1) @(negedge clk);
    replyOk = 1'b1;
    @(negedge clk);
    replyOk = 1'b0;
    chk("R3 no expiry after reply", 32'({tmoIrq, reqBits}), 32'h0);
    repeat (T - 1) @(negedge clk);
    chk("R3 still quiet", 32'(tmoIrq), 32'h0);
    @(negedge clk);
    chk("R3 expiry after reload", 32'(reqBits), 32'h80);

    // R13: idle phase halts timer
    resetDut();
    cntP = 0;
    for (int i = 0; i < 4 * T; i++) begin
      @(negedge clk);
      if (tmoIrq) cntP++;
    end
    chk("R13 idle no expiry", 32'(cntP), 32'd0);

    // R10: receive timer gated by rxFault
    resetDut();
    phase = 3'd7;
    cntP = 0;
    for (int i = 0; i < 3 * T; i++) begin
      @(negedge clk);
      if (tmoIrq) cntP++;
    end
    chk("R10 no fault no expiry", 32'(cntP), 32'd0);
    rxFault = 1'b1;
    cntP = 0;
    for (int i = 0; i < T + 1; i++) begin
      @(negedge clk);
      if (reqDupAck) cntP++;
    end
    chk("R10 fault gives dup ack", 32'(cntP), 32'd1);

    // R12: status accumulates and survives phase changes; R1: cleared by reset
    resetDut();
    phase = 3'd1;
    repeat (T + 1) @(negedge clk);
    phase = 3'd4;
    repeat (T + 1) @(negedge clk);
    chk("R7 rst on first close expiry", 32'(reqBits), 32'h04);
    phase = 3'd0;
    repeat (2 * T) @(negedge clk);
    chk("R12 sticky accumulate", 32'(tmoStatus), 32'h09);
    resetDut();
    chk("R1 status cleared by reset", 32'(tmoStatus), 32'h0);

    finishRun();
  end

endmodule